// File: doc/BRIEF.md
# Timer Channel Register Bank with Guarded Control Clear

This block is the register front end for eight timer channels. A simple write-strobe bus carries full 32-bit words at byte addresses, and the block decodes each access to a per-channel register or to one of a few shared registers. Each channel owns a reload value, two match thresholds and a status word. Reading the status word returns the live count, which comes in from the counting logic. Writing it sends a one-cycle load strobe with the data back to that logic. The counting logic itself is not part of this block.

The channels share one 32-bit control word, with a 4-bit field per channel. The block does not pass the raw field straight to the counter. It drives an applied enable and an applied 3-bit configuration for each channel, and these follow the control word in a fixed order. When the enable is being turned off, it drops before any configuration change takes effect. When the enable is being turned on, the configuration settles first and the enable rises afterwards.

A parameter picks one of two variants for clearing control bits in bulk. In the guarded variant, software must first write an opening key to a key register. After that, a write-ones-to-clear alias of the control word is accepted. In the status variant, the alias always works, and an extra register gathers per-channel interrupt events, which software clears by writing ones.

Top module: `tmr_regbank`

## Requirements
- R1: After reset, the control word, reload, match, key flag and interrupt status registers are all zero, and every applied enable and configuration output is zero.
- R2: Channel c (0..7) sits at byte base 16*c for c<3 and at 16*(c+1) for c>=3. Within a channel, +0 reads the count input, and +4 reload, +8 match A and +12 match B are read/write registers, each of which also drives an output port.
- R3: A write to a channel's +0 word raises that channel's bit of cnt_ld for exactly the next cycle, with ld_val holding the written data.
- R4: The control word at 0x30 is read/write. Channel c owns bits [4c+3:4c]: bit 4c is enable, bit 4c+1 external clock, bit 4c+2 overflow interrupt and bit 4c+3 pulse.
- R5: Applied outputs follow the control word one cycle after it changes. cfg_o[c] is {pulse, overflow, external clock}. A falling enable drops en_o[c] first, with cfg_o held, and cfg_o follows one cycle later. A rising enable updates cfg_o first and raises en_o[c] one cycle later. With no enable change, cfg_o updates one cycle after the control word.
- R6: Guarded variant: a write to 0x38 with wdata[8:1]=0xAE sets the key flag, 0xEA clears it, and any other value leaves it as it is. Reading 0x38 returns the flag in bit 0.
- R7: Guarded variant: a write to 0x3C clears each control bit whose data bit is one, but only while the key flag is set. Otherwise the write is ignored.
- R8: Status variant: a pulse on irq_set[c] sets bit c of the interrupt status, which reads at 0x34 and drives irq_pend. Writing ones to 0x34 clears bits, and a set in the same cycle wins over the clear.
- R9: Status variant: a write to 0x3C clears control bits with no key needed. 0x38 reads zero and ignores writes.
- R10: Undefined or misaligned addresses read zero and ignore writes. This covers 0x3C on read, 0x90 and above, addr[1:0]≠0, 0x34 in the guarded variant and 0x38 in the status variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| cnt_val | input | 8x32 | Live count per channel |
| irq_set | input | 8 | Per-channel interrupt event pulses |
| cnt_ld | output | 8 | One-cycle count load strobes |
| ld_val | output | 32 | Count load value |
| reload_o | output | 8x32 | Reload registers |
| match_a_o | output | 8x32 | First match registers |
| match_b_o | output | 8x32 | Second match registers |
| en_o | output | 8 | Applied channel enables |
| cfg_o | output | 8x3 | Applied channel configuration |
| irq_pend | output | 8 | Interrupt status (zero in guarded variant) |

## Verification
The assertions assume a bus that makes at most one access per cycle. They also assume that wr_en, addr and wdata are stable around the clock edge and that wr_en is low while reset is asserted. The ordering properties assume the control word changes only through bus writes, so any enable or configuration step can be traced to an earlier write. The bench drives every input on the falling edge, holds wr_en low through reset and issues one write at a time. This keeps the stimulus within those assumptions, while back-to-back control writes still exercise the ordering.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned FIELD_W = 4;
  localparam int unsigned CFG_W   = FIELD_W - 1;

  // field bit positions, decoded by the channel sequencer
  localparam int unsigned FB_EN    = 0;
  localparam int unsigned FB_EXT   = 1;
  localparam int unsigned FB_OVF   = 2;
  localparam int unsigned FB_PULSE = 3;

  // word index inside a channel block
  typedef enum logic [1:0] {
    W_STAT   = 2'd0,
    W_RELOAD = 2'd1,
    W_MA     = 2'd2,
    W_MB     = 2'd3
  } word_e;

  localparam int unsigned OFS_CTRL = 'h30;
  localparam int unsigned OFS_AUX  = 'h34;
  localparam int unsigned OFS_KEY  = 'h38;
  localparam int unsigned OFS_CLR  = 'h3C;

  localparam logic [7:0] KEY_OPEN = 8'hAE;
  localparam logic [7:0] KEY_SHUT = 8'hEA;

  typedef struct packed {
    logic  hit_ch;
    word_e word;
    logic  hit_ctrl;
    logic  hit_aux;
    logic  hit_key;
    logic  hit_clr;
  } dec_t;
endpackage

// File: rtl/tmr_regdec.sv
module tmr_regdec
  import tmr_pkg::*;
#(
  parameter int unsigned NCH    = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CHW    = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec,
  output logic [CHW-1:0]    ch
);
  localparam int unsigned BW = ADDR_W - 4;
  localparam logic [BW-1:0] SHARED_BLK = BW'(OFS_CTRL / 16);
  localparam logic [BW-1:0] LOW_LIMIT  = BW'(OFS_CTRL / 16);
  localparam logic [BW-1:0] TOP_BLK    = BW'(NCH);

  logic [BW-1:0] blk;
  logic          aligned;

  assign blk     = addr[ADDR_W-1:4];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    dec = '0;
    dec.word = word_e'(addr[3:2]);
    ch  = '0;
    if (aligned) begin
      if (blk == SHARED_BLK) begin
        dec.hit_ctrl = (addr[3:2] == 2'd0);
        dec.hit_aux  = (addr[3:2] == 2'd1);
        dec.hit_key  = (addr[3:2] == 2'd2);
        dec.hit_clr  = (addr[3:2] == 2'd3);
      end else if (blk < LOW_LIMIT) begin
        dec.hit_ch = 1'b1;
        ch         = CHW'(blk);
      end else if (blk <= TOP_BLK) begin
        dec.hit_ch = 1'b1;
        ch         = CHW'(blk - BW'(1));
      end
    end
  end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned DW  = 32,
  parameter int unsigned CHW = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic [CHW-1:0]          ch,
  input  word_e                   word,
  input  logic [DW-1:0]           wdata,
  output logic [NCH-1:0][DW-1:0]  reload_o,
  output logic [NCH-1:0][DW-1:0]  match_a_o,
  output logic [NCH-1:0][DW-1:0]  match_b_o,
  output logic [NCH-1:0]          ld_stb,
  output logic [DW-1:0]           ld_val
);
  logic [NCH-1:0] ld_d;
  logic           ldv_en;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel, rl_en, ma_en, mb_en;
    assign sel   = wr && (ch == CHW'(c));
    assign rl_en = sel && (word == W_RELOAD);
    assign ma_en = sel && (word == W_MA);
    assign mb_en = sel && (word == W_MB);
    assign ld_d[c] = sel && (word == W_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reload_o[c]  <= '0;
        match_a_o[c] <= '0;
        match_b_o[c] <= '0;
      end else begin
        if (rl_en) reload_o[c]  <= wdata;
        if (ma_en) match_a_o[c] <= wdata;
        if (mb_en) match_b_o[c] <= wdata;
      end
    end
  end

  assign ldv_en = |ld_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_stb <= '0;
      ld_val <= '0;
    end else begin
      ld_stb <= ld_d;
      if (ldv_en) ld_val <= wdata;
    end
  end
endmodule

// File: rtl/tmr_ctrl_seq.sv
module tmr_ctrl_seq
  import tmr_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NCH*FIELD_W-1:0]      ctrl,
  output logic [NCH-1:0]              en_o,
  output logic [NCH-1:0][CFG_W-1:0]   cfg_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_seq
    logic             want_en, en_d;
    logic [CFG_W-1:0] want_cfg, cfg_d;

    assign want_en  = ctrl[c*FIELD_W + FB_EN];
    assign want_cfg = {ctrl[c*FIELD_W + FB_PULSE],
                       ctrl[c*FIELD_W + FB_OVF],
                       ctrl[c*FIELD_W + FB_EXT]};

    always_comb begin
      en_d  = en_o[c];
      cfg_d = cfg_o[c];
      if (en_o[c] && !want_en) begin
        en_d = 1'b0;                       // disable before reconfiguring
      end else begin
        cfg_d = want_cfg;
        if (!en_o[c] && want_en && (cfg_o[c] == want_cfg))
          en_d = 1'b1;                     // enable once config has settled
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_o[c]  <= 1'b0;
        cfg_o[c] <= '0;
      end else begin
        en_o[c]  <= en_d;
        cfg_o[c] <= cfg_d;
      end
    end
  end
endmodule

// File: rtl/tmr_regbank.sv
module tmr_regbank
  import tmr_pkg::*;
#(
  parameter int unsigned NCH       = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DW        = 32,
  parameter bit          STAT_MODE = 1'b0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DW-1:0]                   wdata,
  output logic [DW-1:0]                   rdata,
  input  logic [NCH-1:0][DW-1:0]          cnt_val,
  input  logic [NCH-1:0]                  irq_set,
  output logic [NCH-1:0]                  cnt_ld,
  output logic [DW-1:0]                   ld_val,
  output logic [NCH-1:0][DW-1:0]          reload_o,
  output logic [NCH-1:0][DW-1:0]          match_a_o,
  output logic [NCH-1:0][DW-1:0]          match_b_o,
  output logic [NCH-1:0]                  en_o,
  output logic [NCH-1:0][CFG_W-1:0]       cfg_o,
  output logic [NCH-1:0]                  irq_pend
);
  localparam int unsigned CW  = NCH * FIELD_W;
  localparam int unsigned CHW = $clog2(NCH);

  dec_t           dec;
  logic [CHW-1:0] dch;
  logic [CW-1:0]  ctrl_q, ctrl_d;
  logic           unl_q;
  logic [NCH-1:0] irq_q;
  logic           clr_ok;

  tmr_regdec #(.NCH(NCH), .ADDR_W(ADDR_W), .CHW(CHW)) u_dec (
    .addr (addr),
    .dec  (dec),
    .ch   (dch)
  );

  assign clr_ok = STAT_MODE ? 1'b1 : unl_q;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en && dec.hit_ctrl)
      ctrl_d = wdata[CW-1:0];
    else if (wr_en && dec.hit_clr && clr_ok)
      ctrl_d = ctrl_q & ~wdata[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  if (STAT_MODE) begin : g_stat
    logic [NCH-1:0] irq_d, clr_mask;
    assign clr_mask = (wr_en && dec.hit_aux) ? wdata[NCH-1:0] : '0;
    assign irq_d    = (irq_q & ~clr_mask) | irq_set;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= '0;
      else        irq_q <= irq_d;
    end
    assign unl_q = 1'b0;
  end else begin : g_lock
    logic unl_d, unl_r, key_wr;
    logic unused_irq;
    assign key_wr = wr_en && dec.hit_key;
    always_comb begin
      unl_d = unl_r;
      if (key_wr && (wdata[8:1] == KEY_OPEN))      unl_d = 1'b1;
      else if (key_wr && (wdata[8:1] == KEY_SHUT)) unl_d = 1'b0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) unl_r <= 1'b0;
      else        unl_r <= unl_d;
    end
    assign unl_q      = unl_r;
    assign irq_q      = '0;
    assign unused_irq = ^irq_set;
  end

  tmr_chan_regs #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (wr_en && dec.hit_ch),
    .ch        (dch),
    .word      (dec.word),
    .wdata     (wdata),
    .reload_o  (reload_o),
    .match_a_o (match_a_o),
    .match_b_o (match_b_o),
    .ld_stb    (cnt_ld),
    .ld_val    (ld_val)
  );

  tmr_ctrl_seq #(.NCH(NCH)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .ctrl  (ctrl_q),
    .en_o  (en_o),
    .cfg_o (cfg_o)
  );

  always_comb begin
    rdata = '0;
    if (dec.hit_ch) begin
      unique case (dec.word)
        W_STAT:   rdata = cnt_val[dch];
        W_RELOAD: rdata = reload_o[dch];
        W_MA:     rdata = match_a_o[dch];
        W_MB:     rdata = match_b_o[dch];
        default:  rdata = '0;
      endcase
    end else if (dec.hit_ctrl) begin
      rdata = DW'(ctrl_q);
    end else if (dec.hit_aux && STAT_MODE) begin
      rdata = DW'(irq_q);
    end else if (dec.hit_key && !STAT_MODE) begin
      rdata = DW'(unl_q);
    end
  end

  assign irq_pend = irq_q;
endmodule

// File: rtl/tmr_regbank_chk.sv
module tmr_regbank_chk
  import tmr_pkg::*;
#(
  parameter int unsigned NCH       = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DW        = 32,
  parameter bit          STAT_MODE = 1'b0
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic [ADDR_W-1:0]          addr,
  input logic [DW-1:0]              wdata,
  input logic [NCH-1:0]             irq_set,
  input logic [NCH-1:0]             irq_pend,
  input logic [NCH-1:0]             en_o,
  input logic [NCH-1:0][CFG_W-1:0]  cfg_o,
  input logic [NCH-1:0]             cnt_ld,
  input logic [NCH*FIELD_W-1:0]     ctrl_q,
  input logic                       unl_q
);
  localparam int unsigned CW = NCH * FIELD_W;

  AST_LD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|cnt_ld) |-> ($onehot0(cnt_ld) && $past(wr_en))); // R3

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFS_CTRL)) |=> (ctrl_q == $past(wdata[CW-1:0]))); // R4

  AST_LOCKED_CLR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!STAT_MODE && wr_en && addr == ADDR_W'(OFS_CLR) && !unl_q) |=> $stable(ctrl_q)); // R7

  for (genvar c = 0; c < NCH; c++) begin : g_c
    AST_EN_FALL_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_o[c]) |-> $stable(cfg_o[c])); // R5

    AST_EN_RISE_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_o[c]) |-> ($stable(cfg_o[c]) && $past(ctrl_q[c*FIELD_W + FB_EN]))); // R5

    AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (STAT_MODE && irq_set[c]) |=> irq_pend[c]); // R8
  end
endmodule

bind tmr_regbank tmr_regbank_chk #(
  .NCH(NCH), .ADDR_W(ADDR_W), .DW(DW), .STAT_MODE(STAT_MODE)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata    (wdata),
  .irq_set  (irq_set),
  .irq_pend (irq_pend),
  .en_o     (en_o),
  .cfg_o    (cfg_o),
  .cnt_ld   (cnt_ld),
  .ctrl_q   (ctrl_q),
  .unl_q    (unl_q)
);

// File: tb/tmr_regbank_test.sv
`timescale 1ns/1ps
module tmr_regbank_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [7:0][31:0] cnt_val;
  logic [7:0] irq_set = '0;

  logic [31:0] rdata, rdata_s, ld_val, ld_val_s;
  logic [7:0] cnt_ld, cnt_ld_s, en_o, en_s, irq_pend, irq_s;
  logic [7:0][31:0] rel, ma, mb, rel_s, ma_s, mb_s;
  logic [7:0][2:0] cfg, cfg_s;

  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tmr_regbank #(.STAT_MODE(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cnt_val(cnt_val), .irq_set(irq_set), .cnt_ld(cnt_ld),
    .ld_val(ld_val), .reload_o(rel), .match_a_o(ma), .match_b_o(mb),
    .en_o(en_o), .cfg_o(cfg), .irq_pend(irq_pend));

  tmr_regbank #(.STAT_MODE(1'b1)) uut_s (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata_s), .cnt_val(cnt_val), .irq_set(irq_set), .cnt_ld(cnt_ld_s),
    .ld_val(ld_val_s), .reload_o(rel_s), .match_a_o(ma_s), .match_b_o(mb_s),
    .en_o(en_s), .cfg_o(cfg_s), .irq_pend(irq_s));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference for the guarded instance
  logic [31:0] m_ctrl, m_ldv;
  bit          m_unl;
  logic [31:0] m_rel [8];
  logic [31:0] m_ma [8];
  logic [31:0] m_mb [8];
  bit          m_en [8];
  logic [2:0]  m_cfg [8];
  logic [7:0]  m_ld;
  int mb_blk, mb_w, mb_ch;
  logic [7:0]  exp_en;
  logic [23:0] exp_cfg;
  bit          reg_bad;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_ldv = 0; m_unl = 0; m_ld = 0;
      for (int c = 0; c < 8; c++) begin
        m_rel[c] = 0; m_ma[c] = 0; m_mb[c] = 0; m_en[c] = 0; m_cfg[c] = 0;
      end
    end else begin
      for (int c = 0; c < 8; c++) begin
        if (m_en[c] && !m_ctrl[4*c]) m_en[c] = 0;
        else begin
          if (!m_en[c] && m_ctrl[4*c] && m_cfg[c] == m_ctrl[4*c+1 +: 3]) m_en[c] = 1;
          m_cfg[c] = m_ctrl[4*c+1 +: 3];
        end
      end
      m_ld = 0;
      if (wr_en && addr[1:0] == 2'b00) begin
        mb_blk = int'(addr) / 16;
        mb_w   = int'(addr[3:2]);
        mb_ch  = -1;
        if (mb_blk < 3) mb_ch = mb_blk;
        else if (mb_blk >= 4 && mb_blk <= 8) mb_ch = mb_blk - 1;
        if (mb_ch >= 0) begin
          case (mb_w)
            0: begin m_ld[mb_ch] = 1'b1; m_ldv = wdata; end
            1: m_rel[mb_ch] = wdata;
            2: m_ma[mb_ch]  = wdata;
            default: m_mb[mb_ch] = wdata;
          endcase
        end else if (mb_blk == 3) begin
          if (mb_w == 0) m_ctrl = wdata;
          else if (mb_w == 2 && wdata[8:1] == 8'hAE) m_unl = 1;
          else if (mb_w == 2 && wdata[8:1] == 8'hEA) m_unl = 0;
          else if (mb_w == 3 && m_unl) m_ctrl = m_ctrl & ~wdata;
        end
      end
    end
    #2;
    if (rst_n && !done) begin
      for (int c = 0; c < 8; c++) begin
        exp_en[c] = m_en[c];
        exp_cfg[3*c +: 3] = m_cfg[c];
      end
      chk("R5 applied en (model)", {24'b0, en_o}, {24'b0, exp_en});
      chk("R5 applied cfg (model)", {8'b0, cfg}, {8'b0, exp_cfg});
      reg_bad = 0;
      for (int c = 0; c < 8; c++)
        if (rel[c] !== m_rel[c] || ma[c] !== m_ma[c] || mb[c] !== m_mb[c]) reg_bad = 1;
      chk("R2 channel registers (model)", {31'b0, reg_bad}, 32'b0);
      chk("R3 load strobe (model)", {24'b0, cnt_ld}, {24'b0, m_ld});
      if (m_ld != 0) chk("R3 load value (model)", ld_val, m_ldv);
    end
  end

  // ---------------- stimulus helpers
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v, output logic [31:0] vs);
    addr = a;
    #1;
    v = rdata; vs = rdata_s;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, vs;
    for (int c = 0; c < 8; c++) cnt_val[c] = 32'hC0DE_0000 | c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h30, v, vs); chk("R1 ctrl after reset", v, 0);
    rd(8'h38, v, vs); chk("R1 key flag after reset", v, 0);
    rd(8'h34, v, vs); chk("R1 irq status after reset", vs, 0);
    chk("R1 applied outputs after reset", {en_o, en_s, 16'b0}, 0);

    // R2 address map and register storage
    wr(8'h04, 32'h1111_0000);
    wr(8'h28, 32'h2222_0002);
    wr(8'h4C, 32'h3333_0003);
    wr(8'h84, 32'h4444_0007);
    rd(8'h04, v, vs); chk("R2 ch0 reload readback", v, 32'h1111_0000);
    rd(8'h28, v, vs); chk("R2 ch2 match A readback", v, 32'h2222_0002);
    rd(8'h4C, v, vs); chk("R2 ch3 match B readback", v, 32'h3333_0003);
    chk("R2 ch7 reload port", rel[7], 32'h4444_0007);
    chk("R2 ch3 match B port", mb[3], 32'h3333_0003);
    rd(8'h50, v, vs); chk("R2 ch4 status reads count", v, 32'hC0DE_0004);
    rd(8'h10, v, vs); chk("R2 ch1 status reads count", v, 32'hC0DE_0001);

    // R3 load strobe
    wr(8'h60, 32'hDEAD_BEEF);
    chk("R3 strobe on ch5", {24'b0, cnt_ld}, 32'h20);
    chk("R3 load data", ld_val, 32'hDEAD_BEEF);
    @(negedge clk);
    chk("R3 strobe single cycle", {24'b0, cnt_ld}, 0);

    // R4 control word
    wr(8'h30, 32'h0000_0000);
    rd(8'h30, v, vs); chk("R4 ctrl cleared", v, 0);

    // R5 rising enable with config change: cfg first, enable after
    wr(8'h30, 32'h0000_0007);
    rd(8'h30, v, vs); chk("R4 ctrl readback", v, 32'h7);
    chk("R5 rise: cfg not yet", {29'b0, cfg[0]}, 0);
    @(negedge clk);
    chk("R5 rise: cfg applied first", {29'b0, cfg[0]}, 3'b011);
    chk("R5 rise: enable still low", {31'b0, en_o[0]}, 0);
    @(negedge clk);
    chk("R5 rise: enable after cfg", {31'b0, en_o[0]}, 1);
    // R5 falling enable with config change: enable drops first
    wr(8'h30, 32'h0000_000A);
    @(negedge clk);
    chk("R5 fall: enable dropped", {31'b0, en_o[0]}, 0);
    chk("R5 fall: cfg held", {29'b0, cfg[0]}, 3'b011);
    @(negedge clk);
    chk("R5 fall: cfg after disable", {29'b0, cfg[0]}, 3'b101);
    // R5 no enable change: cfg one cycle after the word
    wr(8'h30, 32'h0000_0020);
    @(negedge clk);
    chk("R5 ch1 cfg without enable", {29'b0, cfg[1]}, 3'b001);
    // back-to-back writes exercised by the per-cycle model
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h30, 32'h5555_5555);
    wr(8'h30, 32'hAAAA_AAAA);
    repeat (3) @(negedge clk);

    // R7 / R6 guarded clear
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h3C, 32'h0000_00F0);
    rd(8'h30, v, vs); chk("R7 clear ignored while locked", v, 32'hFFFF_FFFF);
    wr(8'h38, 32'h0000_015C);
    rd(8'h38, v, vs); chk("R6 open key sets flag", v, 1);
    wr(8'h3C, 32'h0000_00F0);
    rd(8'h30, v, vs); chk("R7 clear accepted when open", v, 32'hFFFF_FF0F);
    wr(8'h38, 32'h0000_01FE);
    rd(8'h38, v, vs); chk("R6 other key leaves flag", v, 1);
    wr(8'h38, 32'h0000_01D4);
    rd(8'h38, v, vs); chk("R6 shut key clears flag", v, 0);

    // R9 status variant clear needs no key
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h3C, 32'h0000_000F);
    rd(8'h30, v, vs);
    chk("R9 status variant clears freely", vs, 32'hFFFF_FFF0);
    chk("R7 guarded variant still locked", v, 32'hFFFF_FFFF);
    wr(8'h38, 32'h0000_015C);
    rd(8'h38, v, vs); chk("R9 key register reads zero", vs, 0);
    wr(8'h38, 32'h0000_01D4);

    // R8 interrupt status
    @(negedge clk); irq_set = 8'h81;
    @(negedge clk); irq_set = 8'h00;
    rd(8'h34, v, vs);
    chk("R8 irq bits set", vs, 32'h81);
    chk("R8 irq port", {24'b0, irq_s}, 32'h81);
    chk("R10 irq register absent in guarded variant", v, 0);
    wr(8'h34, 32'h0000_0001);
    rd(8'h34, v, vs); chk("R8 write-one clears", vs, 32'h80);
    @(negedge clk);
    addr = 8'h34; wdata = 32'h80; wr_en = 1'b1; irq_set = 8'h80;
    @(negedge clk);
    wr_en = 1'b0; irq_set = 8'h00;
    rd(8'h34, v, vs); chk("R8 set wins over clear", vs, 32'h80);

    // R10 undefined and misaligned
    rd(8'h90, v, vs); chk("R10 0x90 reads zero", v | vs, 0);
    rd(8'h3C, v, vs); chk("R10 clear alias reads zero", v | vs, 0);
    wr(8'h05, 32'h1234_5678);
    rd(8'h04, v, vs); chk("R10 misaligned write ignored", v, 32'h1111_0000);
    rd(8'h05, v, vs); chk("R10 misaligned read zero", v, 0);
    wr(8'h94, 32'hFFFF_FFFF);
    rd(8'h30, v, vs); chk("R10 write past map ignored", v, 32'hFFFF_FFFF);
    wr(8'h34, 32'h0000_FFFF);
    rd(8'h30, v, vs); chk("R10 aux write ignored in guarded variant", v, 32'hFFFF_FFFF);

    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule